// File: doc/BRIEF.md
# Legacy Keyboard Port Trap Unit

This block holds one 16-bit legacy-support control word and the trap logic that the word governs. It watches every host I/O access and picks out reads and writes of the keyboard-controller data port (60h) and command port (64h). Each of the four kinds of access sets its own sticky capture flag. Firmware clears these flags by writing a one to them. When the matching enable bit is set, a captured access drives the active-low system-management interrupt output. A USB interrupt request and the end of an A20 gate passthrough sequence can drive that output as well.

The same word decides where the USB interrupt goes. One bit sends it to the PCI interrupt line. Another bit lets it raise the management interrupt. Firmware that wants the operating system to handle the controller writes 0x2000. That value leaves only the PCI routing active and turns off every trap. Firmware that keeps legacy emulation running sets the USB management-interrupt enable and clears the PCI routing bit.

Top module: `kbd_trap_unit`

## Requirements
- R1: After reset, cfg_rdata reads 0x2000 when usb_irq and a20_busy are low. Only bit 13 (PCI routing) is set.
- R2: These bits are read/write and hold the last value written: bits 3:0 (trap enables), bit 4 (USB SMI enable), bit 5 (A20 passthrough enable), bit 7 (A20-end SMI enable) and bit 13 (PCI routing). Writing 0xFFFF to a cleared register makes it read 0x20BF while the live inputs are low.
- R3: Capture flags are bit 8 (read of 60h), bit 9 (write of 60h), bit 10 (read of 64h) and bit 11 (write of 64h). A matching one-cycle io_rd or io_wr strobe sets its flag in the next cycle, whatever its enable holds. Both strobes together set both flags. An access to any other address sets no flag.
- R4: Bits 15 and 11:8 clear when written with 1 and do not change when written with 0. If a capture event arrives in the same cycle as a clear of its flag, the flag stays set.
- R5: Bit 12 reads the live level of usb_irq and bit 6 reads the live level of a20_busy. Writes to bits 12, 6 and 14 have no effect, and bit 14 always reads 0.
- R6: A one-cycle a20_done pulse sets bit 15 in the next cycle.
- R7: smi_n is low exactly when one of these holds: a capture flag in bits 11:8 is set together with its enable in bits 3:0 (same order); bit 15 and bit 7 are both set; usb_irq and bit 4 are both high. Otherwise smi_n is high.
- R8: pci_irq follows usb_irq while bit 13 is set and is held low while bit 13 is clear.
- R9: a20_pt_en follows bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Current control word, including live status bits |
| io_addr | input | 16 | Address of the monitored host I/O access |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_wr | input | 1 | One-cycle I/O write strobe |
| usb_irq | input | 1 | USB controller interrupt request |
| a20_busy | input | 1 | A20 passthrough sequence in progress |
| a20_done | input | 1 | One-cycle pulse when the passthrough sequence ends |
| pci_irq | output | 1 | USB interrupt routed to the PCI interrupt line |
| smi_n | output | 1 | Active-low system-management interrupt |
| a20_pt_en | output | 1 | A20 passthrough enable |

## Verification
The hardest case to reach from the ports is a capture strobe that lands in the same cycle as a write-one-to-clear of that same flag. The bench drives io_rd on 60h on the same clock edge as a configuration write that clears bit 8, and then expects bit 8 to remain set. The bench also sweeps all sixteen trap-enable patterns against each of the four trapped access kinds and against an access to a non-matching address. For every combination it checks both the flag set and the smi_n level.

// File: rtl/kbd_trap_pkg.sv
package kbd_trap_pkg;
    localparam int REG_W    = 16;
    localparam int NUM_TRAP = 4;

    // positions read by firmware
    localparam int B_USB_SMI  = 4;
    localparam int B_A20_EN   = 5;
    localparam int B_A20_BUSY = 6;
    localparam int B_A20_SMI  = 7;
    localparam int B_CAP_LO   = 8;
    localparam int B_USB_ACT  = 12;
    localparam int B_PCI      = 13;
    localparam int B_A20_END  = 15;

    typedef struct packed {
        logic [NUM_TRAP-1:0] trap_en;
        logic                usb_smi_en;
        logic                a20_en;
        logic                a20_smi_en;
        logic                pci_route;
        logic [NUM_TRAP-1:0] cap;
        logic                a20_end;
    } legsup_t;

    localparam legsup_t LEGSUP_RESET = '{
        trap_en:    '0,
        usb_smi_en: 1'b0,
        a20_en:     1'b0,
        a20_smi_en: 1'b0,
        pci_route:  1'b1,
        cap:        '0,
        a20_end:    1'b0
    };
endpackage

// File: rtl/kbd_io_decode.sv
module kbd_io_decode
    import kbd_trap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic [ADDR_W-1:0]   io_addr,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [NUM_TRAP-1:0] trap_hit
);
    // source order: data read, data write, command read, command write
    for (genvar i = 0; i < NUM_TRAP; i++) begin : g_src
        localparam logic [ADDR_W-1:0] PORT = (i < 2) ? DATA_PORT : CMD_PORT;
        localparam bit                IS_RD = (i % 2) == 0;
        logic strobe;
        assign strobe      = IS_RD ? io_rd : io_wr;
        assign trap_hit[i] = strobe && (io_addr == PORT);
    end
endmodule

// File: rtl/kbd_legsup_reg.sv
module kbd_legsup_reg
    import kbd_trap_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr,
    input  logic [REG_W-1:0]    cfg_wdata,
    input  logic [NUM_TRAP-1:0] trap_hit,
    input  logic                a20_done,
    output legsup_t             state_q
);
    legsup_t state_d;

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d.trap_en    = cfg_wdata[NUM_TRAP-1:0];
            state_d.usb_smi_en = cfg_wdata[B_USB_SMI];
            state_d.a20_en     = cfg_wdata[B_A20_EN];
            state_d.a20_smi_en = cfg_wdata[B_A20_SMI];
            state_d.pci_route  = cfg_wdata[B_PCI];
            state_d.cap        = state_q.cap & ~cfg_wdata[B_CAP_LO +: NUM_TRAP];
            state_d.a20_end    = state_q.a20_end & ~cfg_wdata[B_A20_END];
        end
        // new events take priority over a clear in the same cycle
        state_d.cap     = state_d.cap | trap_hit;
        state_d.a20_end = state_d.a20_end | a20_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LEGSUP_RESET;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/kbd_irq_steer.sv
module kbd_irq_steer
    import kbd_trap_pkg::*;
(
    input  legsup_t          state_q,
    input  logic             usb_irq,
    input  logic             a20_busy,
    output logic [REG_W-1:0] rdata,
    output logic             pci_irq,
    output logic             smi_n,
    output logic             a20_pt_en
);
    logic trap_pend;
    logic usb_pend;
    logic a20_pend;

    always_comb begin
        trap_pend = |(state_q.cap & state_q.trap_en);
        usb_pend  = usb_irq && state_q.usb_smi_en;
        a20_pend  = state_q.a20_end && state_q.a20_smi_en;
        smi_n     = !(trap_pend || usb_pend || a20_pend);
        pci_irq   = usb_irq && state_q.pci_route;
        a20_pt_en = state_q.a20_en;

        rdata                         = '0;
        rdata[NUM_TRAP-1:0]           = state_q.trap_en;
        rdata[B_USB_SMI]              = state_q.usb_smi_en;
        rdata[B_A20_EN]               = state_q.a20_en;
        rdata[B_A20_BUSY]             = a20_busy;
        rdata[B_A20_SMI]              = state_q.a20_smi_en;
        rdata[B_CAP_LO +: NUM_TRAP]   = state_q.cap;
        rdata[B_USB_ACT]              = usb_irq;
        rdata[B_PCI]                  = state_q.pci_route;
        rdata[B_A20_END]              = state_q.a20_end;
    end
endmodule

// File: rtl/kbd_trap_unit.sv
module kbd_trap_unit
    import kbd_trap_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] DATA_PORT = 'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT  = 'h64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              usb_irq,
    input  logic              a20_busy,
    input  logic              a20_done,
    output logic              pci_irq,
    output logic              smi_n,
    output logic              a20_pt_en
);
    logic [NUM_TRAP-1:0] trap_hit;
    legsup_t             state_q;

    kbd_io_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_PORT(DATA_PORT),
        .CMD_PORT (CMD_PORT)
    ) u_decode (
        .io_addr (io_addr),
        .io_rd   (io_rd),
        .io_wr   (io_wr),
        .trap_hit(trap_hit)
    );

    kbd_legsup_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_wdata(cfg_wdata),
        .trap_hit (trap_hit),
        .a20_done (a20_done),
        .state_q  (state_q)
    );

    kbd_irq_steer u_steer (
        .state_q  (state_q),
        .usb_irq  (usb_irq),
        .a20_busy (a20_busy),
        .rdata    (cfg_rdata),
        .pci_irq  (pci_irq),
        .smi_n    (smi_n),
        .a20_pt_en(a20_pt_en)
    );
endmodule

// File: rtl/kbd_trap_checker.sv
module kbd_trap_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [15:0]       cfg_rdata,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              usb_irq,
    input logic              pci_irq,
    input logic              smi_n
);
    // R3 and R4: a data-port read is captured even when a clear arrives in the same cycle
    assert_rd60_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && io_addr == ADDR_W'('h60)) |=> cfg_rdata[8]);

    // R4: a flag stays set when no configuration write occurs
    assert_sticky_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[9] && !cfg_wr) |=> cfg_rdata[9]);

    // R7: an enabled captured access holds smi_n low
    assert_trap_smi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[8] && cfg_rdata[0]) |-> !smi_n);

    // R7: an enabled USB interrupt holds smi_n low
    assert_usb_smi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (usb_irq && cfg_rdata[4]) |-> !smi_n);

    // R8: routing bit clear keeps the PCI line quiet
    assert_pci_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[13] |-> !pci_irq);
endmodule

bind kbd_trap_unit kbd_trap_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_rdata(cfg_rdata),
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .usb_irq  (usb_irq),
    .pci_irq  (pci_irq),
    .smi_n    (smi_n)
);

// File: tb/kbd_trap_unit_tb.sv
module kbd_trap_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic        usb_irq = 1'b0;
    logic        a20_busy = 1'b0;
    logic        a20_done = 1'b0;
    logic        pci_irq;
    logic        smi_n;
    logic        a20_pt_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    kbd_trap_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
        .usb_irq(usb_irq), .a20_busy(a20_busy), .a20_done(a20_done),
        .pci_irq(pci_irq), .smi_n(smi_n), .a20_pt_en(a20_pt_en)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] w);
        cfg_wr = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic io_access(input logic [15:0] a, input logic rd, input logic wr);
        io_addr = a;
        io_rd = rd;
        io_wr = wr;
        @(negedge clk);
        io_rd = 1'b0;
        io_wr = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset", cfg_rdata, 16'h2000);
        chk("R1 smi idle", {15'b0, smi_n}, 16'h1);

        // R3 R7: sweep every enable pattern against each access kind
        for (int e = 0; e < 16; e++) begin
            for (int k = 0; k < 5; k++) begin
                logic [15:0] a;
                logic [15:0] flags;
                logic        exp_smi_n;
                cfg_write(16'h8F00 | 16'h2000 | 16'(e));
                chk("R2 enables", cfg_rdata, 16'h2000 | 16'(e));
                a = (k == 4) ? 16'h0061 : ((k < 2) ? 16'h0060 : 16'h0064);
                if (k == 4) io_access(a, 1'b1, 1'b1);
                else        io_access(a, (k % 2) == 0, (k % 2) == 1);
                flags = (k < 4) ? (16'h0100 << k) : 16'h0;
                exp_smi_n = !((k < 4) && e[k]);
                chk("R3 capture", cfg_rdata, 16'h2000 | 16'(e) | flags);
                chk("R7 smi", {15'b0, smi_n}, {15'b0, exp_smi_n});
            end
        end

        // R3: both strobes, far address
        cfg_write(16'h8F00);
        io_access(16'h0060, 1'b1, 1'b1);
        chk("R3 both strobes", cfg_rdata, 16'h0300);
        io_access(16'h0160, 1'b1, 1'b1);
        chk("R3 far address", cfg_rdata, 16'h0300);

        // R4: partial clear
        io_access(16'h0064, 1'b1, 1'b1);
        chk("R4 all set", cfg_rdata, 16'h0F00);
        cfg_write(16'h0A00);
        chk("R4 partial clear", cfg_rdata, 16'h0500);

        // R4: capture wins over same-cycle clear
        cfg_wr = 1'b1; cfg_wdata = 16'h0100;
        io_addr = 16'h0060; io_rd = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0; io_rd = 1'b0;
        #1;
        chk("R4 set wins", cfg_rdata, 16'h0500);

        // R2 R5: all ones on clean register
        cfg_write(16'h8F00);
        cfg_write(16'hFFFF);
        chk("R2 write all", cfg_rdata, 16'h20BF);
        chk("R9 a20 enable", {15'b0, a20_pt_en}, 16'h1);
        cfg_write(16'h0000);
        chk("R9 a20 disable", {15'b0, a20_pt_en}, 16'h0);

        // R5: live bits
        usb_irq = 1'b1; a20_busy = 1'b1; #1;
        chk("R5 live bits", cfg_rdata, 16'h1040);
        chk("R8 pci gated", {15'b0, pci_irq}, 16'h0);
        chk("R7 usb no enable", {15'b0, smi_n}, 16'h1);
        cfg_write(16'h0010);
        chk("R7 usb smi", {15'b0, smi_n}, 16'h0);
        cfg_write(16'h2000);
        chk("R8 pci routed", {15'b0, pci_irq}, 16'h1);
        chk("R7 usb smi off", {15'b0, smi_n}, 16'h1);
        usb_irq = 1'b0; a20_busy = 1'b0; #1;
        chk("R8 pci follows", {15'b0, pci_irq}, 16'h0);
        chk("R5 live clear", cfg_rdata, 16'h2000);

        // R6 R7: passthrough end
        a20_done = 1'b1;
        @(negedge clk);
        a20_done = 1'b0;
        #1;
        chk("R6 end flag", cfg_rdata, 16'hA000);
        chk("R7 a20 no enable", {15'b0, smi_n}, 16'h1);
        cfg_write(16'h2080);
        chk("R7 a20 smi", {15'b0, smi_n}, 16'h0);
        cfg_write(16'hA080);
        chk("R6 clear", cfg_rdata, 16'h2080);
        chk("R7 a20 smi off", {15'b0, smi_n}, 16'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule